// File: doc/BRIEF.md
# DAC Command and Register Controller

This block sits behind the serial receiver of a single-channel digital-to-analog converter. It takes each complete 24-bit command word and drives the two register stages of the converter. The first stage holds the next code. The second stage holds the code the converter is actually showing. A 4-bit command field chooses among these actions: load the first stage, copy the first stage into the second, do both, power down, or nothing. Unknown command codes are ignored.

An active-low load pin gives a second way to copy the first stage into the second. The pin passes through a synchronizer and acts on its level. Its effect depends on whether the serial receiver is in the middle of a word. Power-down clears whenever the second stage is updated. Each exit from power-down starts a settling timer. The timer length is set in clock cycles by one of two parameters, and a configuration input chooses which one applies.

Top module: `dac_cmd_ctrl`

## Requirements
- R1: After reset, both register stages hold zero-scale (all zeros), or mid-scale (only the code MSB set) when RESET_MID=1. `pwr_down` and `settle_busy` are both 0 after reset.
- R2: Word bits [23:20] carry the command and bits [19:16] are ignored. The code is taken from bits [15:16-CODE_W], MSB first. Bits below that range are ignored.
- R3: Command 4'b0000 loads the code into the input register only. `dac_code` keeps its value until a later update.
- R4: Command 4'b0001 copies the input register to `dac_code` and clears `pwr_down`. Both take effect on the clock edge that samples `word_valid`.
- R5: Command 4'b0011 loads the input register and then copies the new code to `dac_code` on the same edge. It also clears `pwr_down`.
- R6: Command 4'b0100 sets `pwr_down`. It leaves both registers unchanged, and its code field is discarded.
- R7: Command 4'b1111 and every code other than 0000, 0001, 0011 and 0100 change neither register nor `pwr_down`.
- R8: While `xfer_busy` is 0, a low level on `load_n` copies the input register to `dac_code` on every cycle and clears `pwr_down`. The level takes effect on the third rising edge after it is applied, because of two synchronizer stages.
- R9: While `xfer_busy` is 1 and no word completes, a synchronized low on `load_n` clears `pwr_down` but leaves `dac_code` unchanged.
- R10: When a word completes while the synchronized `load_n` is low, its command executes first. Then `dac_code` takes the resulting input register value on the same edge, whatever the state of `xfer_busy`.
- R11: Each exit from power-down raises `settle_busy` for exactly SETTLE_NOM cycles when `supply_low` is 0, or SETTLE_LOW cycles when it is 1. The count starts in the cycle after the exit edge.
- R12: `settle_busy` is 0 whenever `pwr_down` is 1. Entering power-down cancels any settling period that is still running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| word_valid | input | 1 | One-cycle strobe: a complete word is present on `word_data` |
| word_data | input | 24 | Received command word |
| xfer_busy | input | 1 | Serial receiver is in the middle of a word |
| load_n | input | 1 | Asynchronous active-low load pin |
| supply_low | input | 1 | Selects the long settling count |
| dac_code | output | CODE_W | DAC register contents |
| pwr_down | output | 1 | Converter is powered down |
| settle_busy | output | 1 | Power-up settling is in progress |

## Verification
The bench sweeps all sixteen command codes against a set of data patterns whose don't-care bits are filled with junk. After each word it sends an update word that exposes the hidden input register. This catches several faults: a reserved code decoded as a write, a power-down that corrupts a stage, and a code taken from the wrong bit slice. The load pin is tested separately at three moments: outside a transfer, pulsed during a transfer, and still low when a word completes. A wrong interlock would show up as a premature `dac_code` change, a missed wake-up, or a lost post-command update. Settling is measured to the exact cycle for both supply settings and cut short by re-entering power-down, so an off-by-one timer or a timer left running in power-down is reported.

// File: rtl/dcc_pkg.sv
package dcc_pkg;

   localparam int WORD_W = 24;
   localparam int OP_W   = 4;

   localparam logic [OP_W-1:0] OP_LOAD_IN  = 4'b0000;
   localparam logic [OP_W-1:0] OP_COPY     = 4'b0001;
   localparam logic [OP_W-1:0] OP_LOAD_CPY = 4'b0011;
   localparam logic [OP_W-1:0] OP_SLEEP    = 4'b0100;
   localparam logic [OP_W-1:0] OP_IDLE     = 4'b1111;

   typedef struct packed {
      logic wr_in;
      logic upd;
      logic sleep;
   } dcc_act_t;

   function automatic dcc_act_t dcc_decode_op(input logic [OP_W-1:0] op);
      dcc_act_t a;
      a = '0;
      unique case (op)
         OP_LOAD_IN:  a.wr_in = 1'b1;
         OP_COPY:     a.upd   = 1'b1;
         OP_LOAD_CPY: begin
            a.wr_in = 1'b1;
            a.upd   = 1'b1;
         end
         OP_SLEEP:    a.sleep = 1'b1;
         default:     a = '0;
      endcase
      return a;
   endfunction

endpackage

// File: rtl/dcc_sync.sv
module dcc_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_n,
   output logic pin_n_sync
);

   initial begin
      if (STAGES < 2) $error("dcc_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] sh;

   always_ff @(posedge clk) begin
      if (!rst_n) sh <= '1;
      else        sh <= {sh[STAGES-2:0], pin_n};
   end

   assign pin_n_sync = sh[STAGES-1];

endmodule

// File: rtl/dcc_decode.sv
module dcc_decode
   import dcc_pkg::*;
#(
   parameter int CODE_W = 16
) (
   input  logic              word_valid,
   input  logic [WORD_W-1:0] word_data,
   output dcc_act_t          act,
   output logic [CODE_W-1:0] code
);

   localparam int PAD_W = 16 - CODE_W;

   always_comb begin
      act = '0;
      if (word_valid) act = dcc_decode_op(word_data[WORD_W-1 -: OP_W]);
   end

   generate
      if (PAD_W == 0) begin : g_full
         assign code = word_data[15:0];
      end else begin : g_trim
         logic [PAD_W-1:0] unused_pad;
         assign code       = word_data[15 -: CODE_W];
         assign unused_pad = word_data[PAD_W-1:0];
      end
   endgenerate

endmodule

// File: rtl/dcc_regs.sv
module dcc_regs
   import dcc_pkg::*;
#(
   parameter int CODE_W    = 16,
   parameter bit RESET_MID = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  dcc_act_t          act,
   input  logic              word_valid,
   input  logic [CODE_W-1:0] code,
   input  logic              ld_low,
   input  logic              xfer_busy,
   output logic [CODE_W-1:0] dac_q,
   output logic              pd_q,
   output logic              wake,
   output logic              sleep_now
);

   localparam logic [CODE_W-1:0] RST_VAL =
      RESET_MID ? {1'b1, {(CODE_W-1){1'b0}}} : '0;

   logic [CODE_W-1:0] in_q, in_nx, dac_nx;
   logic              ld_copy, do_copy, pd_nx;

   // the pin copies only outside a transfer, or at the edge where a word lands
   assign ld_copy = ld_low && (!xfer_busy || word_valid);
   assign do_copy = act.upd || ld_copy;

   always_comb begin
      in_nx  = act.wr_in ? code : in_q;
      dac_nx = do_copy ? in_nx : dac_q;
      pd_nx  = pd_q;
      if (act.sleep) pd_nx = 1'b1;
      if (act.upd || ld_low) pd_nx = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         in_q  <= RST_VAL;
         dac_q <= RST_VAL;
         pd_q  <= 1'b0;
      end else begin
         in_q  <= in_nx;
         dac_q <= dac_nx;
         pd_q  <= pd_nx;
      end
   end

   assign wake      = pd_q && !pd_nx;
   assign sleep_now = pd_nx;

endmodule

// File: rtl/dcc_settle.sv
module dcc_settle #(
   parameter int SETTLE_NOM = 1200,
   parameter int SETTLE_LOW = 3000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic wake,
   input  logic sleep_now,
   input  logic supply_low,
   output logic busy
);

   localparam int MAXC = (SETTLE_NOM > SETTLE_LOW) ? SETTLE_NOM : SETTLE_LOW;
   localparam int CW   = $clog2(MAXC + 1);

   initial begin
      if (SETTLE_NOM < 1 || SETTLE_LOW < 1)
         $error("dcc_settle: settling counts must be at least 1");
   end

   logic [CW-1:0] cnt;
   logic [CW-1:0] lim;

   assign lim = supply_low ? CW'(SETTLE_LOW) : CW'(SETTLE_NOM);

   always_ff @(posedge clk) begin
      if (!rst_n)          cnt <= '0;
      else if (wake)       cnt <= lim;
      else if (sleep_now)  cnt <= '0;
      else if (cnt != '0)  cnt <= cnt - 1'b1;
   end

   assign busy = (cnt != '0);

endmodule

// File: rtl/dac_cmd_ctrl.sv
module dac_cmd_ctrl
   import dcc_pkg::*;
#(
   parameter int CODE_W      = 16,
   parameter bit RESET_MID   = 1'b0,
   parameter int SETTLE_NOM  = 1200,
   parameter int SETTLE_LOW  = 3000,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              word_valid,
   input  logic [23:0]       word_data,
   input  logic              xfer_busy,
   input  logic              load_n,
   input  logic              supply_low,
   output logic [CODE_W-1:0] dac_code,
   output logic              pwr_down,
   output logic              settle_busy
);

   initial begin
      if (CODE_W != 12 && CODE_W != 14 && CODE_W != 16)
         $error("dac_cmd_ctrl: CODE_W must be 12, 14 or 16");
   end

   dcc_act_t          act;
   logic [CODE_W-1:0] code;
   logic              load_n_s, ld_low, wake, sleep_now;

   dcc_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .pin_n(load_n), .pin_n_sync(load_n_s)
   );
   assign ld_low = !load_n_s;

   dcc_decode #(.CODE_W(CODE_W)) u_dec (
      .word_valid(word_valid), .word_data(word_data), .act(act), .code(code)
   );

   dcc_regs #(.CODE_W(CODE_W), .RESET_MID(RESET_MID)) u_regs (
      .clk(clk), .rst_n(rst_n), .act(act), .word_valid(word_valid),
      .code(code), .ld_low(ld_low), .xfer_busy(xfer_busy),
      .dac_q(dac_code), .pd_q(pwr_down), .wake(wake), .sleep_now(sleep_now)
   );

   dcc_settle #(.SETTLE_NOM(SETTLE_NOM), .SETTLE_LOW(SETTLE_LOW)) u_settle (
      .clk(clk), .rst_n(rst_n), .wake(wake), .sleep_now(sleep_now),
      .supply_low(supply_low), .busy(settle_busy)
   );

endmodule

// File: rtl/dac_cmd_ctrl_chk.sv
module dac_cmd_ctrl_chk #(
   parameter int CODE_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              word_valid,
   input logic [23:0]       word_data,
   input logic              xfer_busy,
   input logic              ld_low,
   input logic [CODE_W-1:0] dac_code,
   input logic              pwr_down,
   input logic              settle_busy
);

   logic [3:0] op;
   logic       reserved;
   assign op       = word_data[23:20];
   assign reserved = !(op == 4'b0000 || op == 4'b0001 || op == 4'b0011 || op == 4'b0100);

   p_sleep_keeps_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pwr_down) |-> $stable(dac_code));

   p_sleep_cmd_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (word_valid && op == 4'b0100 && !ld_low) |=> pwr_down);

   p_reserved_noop_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (word_valid && reserved && !ld_low) |=> ($stable(dac_code) && $stable(pwr_down)));

   p_busy_holds_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_busy && !word_valid) |=> $stable(dac_code));

   p_wake_starts_settle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pwr_down) |-> settle_busy);

   p_no_settle_asleep_r12: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_down |-> !settle_busy);

endmodule

bind dac_cmd_ctrl dac_cmd_ctrl_chk #(.CODE_W(CODE_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .word_valid(word_valid), .word_data(word_data),
   .xfer_busy(xfer_busy), .ld_low(ld_low), .dac_code(dac_code),
   .pwr_down(pwr_down), .settle_busy(settle_busy)
);

// File: tb/test_dac_cmd_ctrl.sv
module test_dac_cmd_ctrl;

   localparam int CW   = 12;
   localparam int SNOM = 12;
   localparam int SLOW = 30;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          word_valid = 1'b0;
   logic [23:0]   word_data = '0;
   logic          xfer_busy = 1'b0;
   logic          load_n = 1'b1;
   logic          supply_low = 1'b0;
   logic [CW-1:0] dac_code;
   logic          pwr_down;
   logic          settle_busy;

   int  n_chk = 0;
   int  n_bad = 0;
   bit  done  = 1'b0;

   always #5 clk = ~clk;

   dac_cmd_ctrl #(.CODE_W(CW), .RESET_MID(1'b1), .SETTLE_NOM(SNOM),
                  .SETTLE_LOW(SLOW), .SYNC_STAGES(2)) i_dac_cmd_ctrl (
      .clk(clk), .rst_n(rst_n), .word_valid(word_valid), .word_data(word_data),
      .xfer_busy(xfer_busy), .load_n(load_n), .supply_low(supply_low),
      .dac_code(dac_code), .pwr_down(pwr_down), .settle_busy(settle_busy)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   // drive one complete word for one cycle; returns at the negedge after the edge
   task automatic send(input logic [3:0] op, input logic [3:0] junk, input logic [15:0] d);
      @(negedge clk);
      word_data  = {op, junk, d};
      word_valid = 1'b1;
      @(negedge clk);
      word_valid = 1'b0;
      word_data  = 24'hFFFFFF;
   endtask

   task automatic cycles(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   function automatic logic [CW-1:0] cd(input logic [15:0] d);
      return d[15 -: CW];
   endfunction

   logic [CW-1:0] m_in, m_dac;
   logic          m_pd;

   initial begin
      m_in  = 12'h800;
      m_dac = 12'h800;
      m_pd  = 1'b0;
      cycles(3);
      // R1: mid-scale reset option
      chk("R1 dac", dac_code, 12'h800);
      chk("R1 pd", pwr_down, 0);
      chk("R1 settle", settle_busy, 0);
      @(negedge clk) rst_n = 1'b1;
      send(4'b0001, 4'h0, 16'h0000);
      chk("R1 input reg", dac_code, 12'h800);
      m_dac = 12'h800;

      // R2..R7: sweep every command against junk-laden data
      for (int op = 0; op < 16; op++) begin
         for (int k = 0; k < 8; k++) begin
            logic [15:0] d;
            logic [3:0]  o;
            d = 16'(op * 16'h0931 + k * 16'h1D4B + 16'h05A7);
            o = 4'(op);
            send(o, 4'(k + op), d);
            if (o == 4'b0000 || o == 4'b0011) m_in = cd(d);
            if (o == 4'b0001 || o == 4'b0011) begin m_dac = m_in; m_pd = 1'b0; end
            if (o == 4'b0100) m_pd = 1'b1;
            chk("R2-7 sweep dac R3 R4 R5 R6 R7", dac_code, m_dac);
            chk("R4 R5 R6 R7 sweep pd", pwr_down, m_pd);
            send(4'b0001, 4'hA, 16'hFFFF);
            m_dac = m_in; m_pd = 1'b0;
            chk("R2 R3 R6 R7 input reveal", dac_code, m_in);
         end
      end

      // R8: level load outside a transfer, with synchronizer latency
      send(4'b0000, 4'h3, 16'h4440);
      chk("R8 setup", dac_code, m_dac);
      send(4'b0100, 4'h0, 16'h0000);
      @(negedge clk) load_n = 1'b0;
      cycles(2);
      chk("R8 latency", dac_code, m_dac);
      chk("R8 latency pd", pwr_down, 1);
      cycles(1);
      chk("R8 copy", dac_code, 12'h444);
      chk("R8 wake", pwr_down, 0);
      send(4'b0000, 4'h0, 16'h7890);
      chk("R8 tracking", dac_code, 12'h789);
      @(negedge clk) load_n = 1'b1;
      cycles(3);
      m_in = 12'h789; m_dac = 12'h789;

      // R9: pulse during a transfer wakes but does not copy
      send(4'b0000, 4'h0, 16'h1230);
      m_in = 12'h123;
      send(4'b0100, 4'h0, 16'hFFF0);
      chk("R9 setup pd", pwr_down, 1);
      @(negedge clk) xfer_busy = 1'b1;
      load_n = 1'b0;
      cycles(3);
      load_n = 1'b1;
      cycles(4);
      chk("R9 no copy", dac_code, 12'h789);
      chk("R9 woke", pwr_down, 0);
      chk("R9 R11 settle", settle_busy, 1);
      xfer_busy = 1'b0;
      cycles(2);
      chk("R9 still held", dac_code, 12'h789);
      send(4'b0001, 4'h0, 16'h0000);
      chk("R9 input intact", dac_code, 12'h123);

      // R10: pin still low when a word completes
      @(negedge clk) xfer_busy = 1'b1;
      load_n = 1'b0;
      cycles(4);
      chk("R10 held mid-word", dac_code, 12'h123);
      send(4'b0000, 4'h0, 16'hABC0);
      chk("R10 exec then copy", dac_code, 12'hABC);
      load_n = 1'b1;
      cycles(3);
      xfer_busy = 1'b0;
      send(4'b0100, 4'h0, 16'h0000);
      @(negedge clk) xfer_busy = 1'b1;
      load_n = 1'b0;
      cycles(3);
      send(4'b0100, 4'h0, 16'h0000);
      chk("R10 sleep then copy", pwr_down, 0);
      load_n = 1'b1;
      cycles(3);
      xfer_busy = 1'b0;
      cycles(SLOW + 2);

      // R11: exact settling length, both supplies
      for (int s = 0; s < 2; s++) begin
         int lim;
         supply_low = 1'(s);
         lim = s ? SLOW : SNOM;
         send(4'b0100, 4'h0, 16'h0000);
         chk("R12 asleep", settle_busy, 0);
         send(4'b0001, 4'h0, 16'h0000);
         chk("R11 start", settle_busy, 1);
         cycles(lim - 1);
         chk("R11 last busy", settle_busy, 1);
         cycles(1);
         chk("R11 end", settle_busy, 0);
      end

      // R12: re-entering power-down cancels settling
      supply_low = 1'b0;
      send(4'b0100, 4'h0, 16'h0000);
      send(4'b0011, 4'h0, 16'h5550);
      cycles(3);
      chk("R12 mid settle", settle_busy, 1);
      send(4'b0100, 4'h0, 16'h0000);
      chk("R12 cancel", settle_busy, 0);
      cycles(SNOM);
      chk("R12 stays idle", settle_busy, 0);
      chk("R6 code kept", dac_code, 12'h555);

      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      #1500000;
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

endmodule